// File: doc/BRIEF.md
# Read-to-Acquire Hardware Lock Bank

This block arbitrates one shared resource between several software functions through a bank of lock registers, one register per function, placed at a fixed byte stride above a base address. Every register in the bank views the same single busy flag. A read is the acquire operation. It returns the flag's value from before the read and leaves the flag set. A reader that sees busy clear therefore holds the lock, and a reader that sees busy set has lost. The lock also records the function whose register was read when it was taken. Only a zero written to that owner's register releases it.

Several request ports (bus masters) share the bank. Each port issues commands with valid/ready. The bank accepts at most one command per cycle. When more than one port is valid, the lowest-numbered port wins and the others see ready low. A port whose ready is low must hold its command, unchanged, until ready is high. The read word comes back on that port's response pins one cycle after acceptance. The response cannot be stalled, so the requester must be able to take it in that cycle. Retry policy, back-off and fairness are left to the software that uses the bank.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset the flag is clear and no owner is recorded, so the first valid read returns the word 0x00000000.
- R2: A read of any in-range register returns its old state in a single word: bit 0 holds the busy flag before the read, and bits [8 +: FID_W] hold the owner before the read (zero when the flag was clear). After the read the flag is set. If the flag was clear, the owner becomes the function whose register was read.
- R3: A read while the flag is set returns bit 0 = 1 with the current owner, and leaves both the flag and the owner unchanged.
- R4: A write of the all-zero word to the owner's register clears the flag. The next read then returns 0.
- R5: A write to any register other than the owner's has no effect on the flag or the owner.
- R6: A write of a non-zero word, even to the owner's register, has no effect.
- R7: Function f's register sits at BASE_ADDR + f*STRIDE. An address below the base, not aligned to the stride, or at or past function N_FUNC misses. A read that misses returns 0x00000001 and changes nothing. A write that misses changes nothing.
- R8: All registers share one flag. Once any function holds the lock, a read through any other function's register returns busy.
- R9: At most one command is accepted per cycle. Among the valid ports, the lowest-numbered one gets ready, and the others get ready low until it has gone.
- R10: A port's response valid pulses for exactly one cycle, in the cycle after its command was accepted, and carries the read word. Nothing is returned on ports whose commands were not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N_PORT | Command valid, one bit per port |
| cmd_ready | output | N_PORT | Command accepted this cycle, one bit per port |
| cmd_write | input | N_PORT | 1 = write (release), 0 = read (acquire), per port |
| cmd_addr | input | N_PORT*ADDR_W | Byte address per port, port p at [p*ADDR_W +: ADDR_W] |
| cmd_wdata | input | N_PORT*DATA_W | Write word per port, port p at [p*DATA_W +: DATA_W] |
| rsp_valid | output | N_PORT | Response valid, one bit per port, one cycle after acceptance |
| rsp_rdata | output | N_PORT*DATA_W | Read word per port, port p at [p*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its default parameters: eight functions, three request ports, a 16-bit address, a base of 0x0400 and a stride of 4. Three ports allow same-cycle contention between the lowest and the highest port, with a middle port that is idle. The 16-bit address reaches all three kinds of miss: below the base, misaligned, and past the last function. Eight functions leave room for owner and non-owner writes to land on distinct registers, so foreign releases and reads through other functions' registers are exercised along with the owner's own accesses.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // position of the busy flag in the read word
  localparam int unsigned BUSY_BIT  = 0;
  // lowest bit of the owner field in the read word
  localparam int unsigned OWNER_LSB = 8;

  typedef enum logic {
    SEM_RD = 1'b0,
    SEM_WR = 1'b1
  } sem_op_e;
endpackage

// File: rtl/sem_arb.sv
module sem_arb #(
  parameter int unsigned N_PORT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] req,
  output logic [N_PORT-1:0] grant
);
  // taken[i] is set when a lower-numbered port already claimed the cycle
  logic [N_PORT:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N_PORT; i++) begin : g_prio
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> grant[0]);
endmodule

// File: rtl/sem_decode.sv
module sem_decode #(
  parameter int unsigned N_FUNC    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned STRIDE    = 4,
  parameter int unsigned FID_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [FID_W-1:0]  fid
);
  localparam int unsigned SH = $clog2(STRIDE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;
  logic              below;
  logic              aligned;
  logic              in_bank;

  assign below   = addr < BASE_ADDR;
  assign off     = addr - BASE_ADDR;
  assign idx     = off >> SH;
  assign in_bank = idx < ADDR_W'(N_FUNC);

  if (SH > 0) begin : g_align
    assign aligned = off[SH-1:0] == '0;
  end else begin : g_noalign
    assign aligned = 1'b1;
  end

  assign hit = !below && aligned && in_bank;
  assign fid = idx[FID_W-1:0];
endmodule

// File: rtl/sem_core.sv
module sem_core #(
  parameter int unsigned FID_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic              acc_hit,
  input  logic [FID_W-1:0]  acc_fid,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_word
);
  import sem_pkg::*;

  logic             busy_q;
  logic [FID_W-1:0] owner_q;
  logic             do_take;
  logic             do_free;

  // a read through any register tests and sets the one shared flag
  assign do_take = acc_vld && acc_hit && (acc_wr == SEM_RD);
  // release: zero word, owner's register, lock held
  assign do_free = acc_vld && acc_hit && (acc_wr == SEM_WR) && busy_q &&
                   (acc_fid == owner_q) && (acc_wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (do_take) begin
      busy_q <= 1'b1;
      if (!busy_q) owner_q <= acc_fid;
    end else if (do_free) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end
  end

  // word returned to the reader: state before this access
  always_comb begin
    rd_word = '0;
    if (acc_hit) begin
      rd_word[BUSY_BIT]            = busy_q;
      rd_word[OWNER_LSB +: FID_W]  = owner_q;
    end else begin
      rd_word[BUSY_BIT] = 1'b1;
    end
  end

  // R2
  rd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && !acc_wr) |=> busy_q);

  // R2
  first_reader_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && !acc_wr && !busy_q) |=> (owner_q == $past(acc_fid)));

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(acc_vld && acc_wr)) |=> (busy_q && $stable(owner_q)));

  // R4
  owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && acc_wr && busy_q && acc_fid == owner_q &&
     acc_wdata == '0) |=> !busy_q);

  // R5
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && acc_hit && acc_fid != owner_q) |=>
      ($stable(busy_q) && $stable(owner_q)));

  // R6
  nonzero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && acc_wdata != '0) |=>
      ($stable(busy_q) && $stable(owner_q)));

  // R7
  miss_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_hit) |=> ($stable(busy_q) && $stable(owner_q)));
endmodule

// File: rtl/sem_rsp.sv
module sem_rsp #(
  parameter int unsigned N_PORT = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORT-1:0]        grant,
  input  logic [DATA_W-1:0]        rd_word,
  output logic [N_PORT-1:0]        rsp_valid,
  output logic [N_PORT*DATA_W-1:0] rsp_rdata
);
  for (genvar i = 0; i < N_PORT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[i]                 <= 1'b0;
        rsp_rdata[i*DATA_W +: DATA_W] <= '0;
      end else begin
        rsp_valid[i] <= grant[i];
        if (grant[i]) rsp_rdata[i*DATA_W +: DATA_W] <= rd_word;
      end
    end

    // R10
    rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> rsp_valid[i]);

    // R10
    no_rsp_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant[i] |=> !rsp_valid[i]);
  end
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank #(
  parameter int unsigned N_FUNC    = 8,
  parameter int unsigned N_PORT    = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400,
  parameter int unsigned STRIDE    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORT-1:0]        cmd_valid,
  output logic [N_PORT-1:0]        cmd_ready,
  input  logic [N_PORT-1:0]        cmd_write,
  input  logic [N_PORT*ADDR_W-1:0] cmd_addr,
  input  logic [N_PORT*DATA_W-1:0] cmd_wdata,
  output logic [N_PORT-1:0]        rsp_valid,
  output logic [N_PORT*DATA_W-1:0] rsp_rdata
);
  localparam int unsigned FID_W = (N_FUNC > 1) ? $clog2(N_FUNC) : 1;

  logic [N_PORT-1:0] grant;
  logic              sel_vld;
  logic              sel_wr;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_hit;
  logic [FID_W-1:0]  sel_fid;
  logic [DATA_W-1:0] rd_word;

  sem_arb #(.N_PORT(N_PORT)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cmd_valid),
    .grant (grant)
  );

  assign cmd_ready = grant;
  assign sel_vld   = |grant;

  // one-hot grant steers the winning port's command onto the shared path
  always_comb begin
    sel_wr    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_PORT; i++) begin
      sel_wr    = sel_wr | (cmd_write[i] & grant[i]);
      sel_addr  = sel_addr  | (cmd_addr[i*ADDR_W +: ADDR_W]  & {ADDR_W{grant[i]}});
      sel_wdata = sel_wdata | (cmd_wdata[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
    end
  end

  sem_decode #(
    .N_FUNC    (N_FUNC),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .STRIDE    (STRIDE),
    .FID_W     (FID_W)
  ) u_dec (
    .addr (sel_addr),
    .hit  (sel_hit),
    .fid  (sel_fid)
  );

  sem_core #(.FID_W(FID_W), .DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (sel_vld),
    .acc_wr    (sel_wr),
    .acc_hit   (sel_hit),
    .acc_fid   (sel_fid),
    .acc_wdata (sel_wdata),
    .rd_word   (rd_word)
  );

  sem_rsp #(.N_PORT(N_PORT), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .rd_word   (rd_word),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: tb/hw_sem_bank_test.sv
module hw_sem_bank_test;
  localparam int NF = 8;
  localparam int NP = 3;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] BASE = 16'h0400;
  localparam int STR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    cmd_valid = '0;
  logic [NP-1:0]    cmd_ready;
  logic [NP-1:0]    cmd_write = '0;
  logic [NP*AW-1:0] cmd_addr  = '0;
  logic [NP*DW-1:0] cmd_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic [NP*DW-1:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit       m_busy  = 0;
  int       m_owner = 0;

  always #4 clk = ~clk;

  hw_sem_bank uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // bench-side address decode per R7: -1 on a miss
  function automatic int fid_of(input logic [AW-1:0] a);
    int off;
    if (a < BASE) return -1;
    off = int'(a - BASE);
    if (off % STR != 0) return -1;
    if (off / STR >= NF) return -1;
    return off / STR;
  endfunction

  // expected read word from the model, then the model update (R2..R8)
  function automatic logic [31:0] model(input bit wr, input logic [AW-1:0] a,
                                        input logic [31:0] d);
    int f;
    logic [31:0] w;
    f = fid_of(a);
    if (f < 0) return 32'h1;
    w = {23'd0, m_owner[0 +: 3], 7'd0, m_busy};
    if (!wr) begin
      if (!m_busy) m_owner = f;
      m_busy = 1;
    end else if (m_busy && f == m_owner && d == 0) begin
      m_busy = 0;
      m_owner = 0;
    end
    return w;
  endfunction

  task automatic access(input int p, input bit wr, input logic [AW-1:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    cmd_valid[p] = 1'b1;
    cmd_write[p] = wr;
    cmd_addr[p*AW +: AW] = a;
    cmd_wdata[p*DW +: DW] = d;
    #1;
    while (!cmd_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid[p] = 1'b0;
    chk("R10 rsp_valid after accept", {31'd0, rsp_valid[p]}, 32'h1);
    rd = rsp_rdata[p*DW +: DW];
  endtask

  task automatic op(input string req, input int p, input bit wr,
                    input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd, exp;
    exp = model(wr, a, d);
    access(p, wr, a, d, rd);
    if (!wr) chk(req, rd, exp);
  endtask

  function automatic logic [AW-1:0] reg_of(input int f);
    return BASE + AW'(f * STR);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r2;
    void'($urandom(32'd5150));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no response after reset", {29'd0, rsp_valid}, 32'h0);

    // R1 / R2: first read acquires, owner 2
    op("R1 first read returns 0", 1, 0, reg_of(2), 0);
    // R3 / R8: reads via other registers see busy with owner 2
    op("R8 shared flag via fn5", 0, 0, reg_of(5), 0);
    op("R3 repeated read keeps owner", 2, 0, reg_of(2), 0);
    // R5: foreign zero write ignored
    op("R5 foreign write", 0, 1, reg_of(3), 0);
    op("R5 still held by owner 2", 0, 0, reg_of(7), 0);
    // R6: non-zero owner write ignored
    op("R6 nonzero write", 1, 1, reg_of(2), 32'h1);
    op("R6 still held after nonzero write", 1, 0, reg_of(0), 0);
    // R7: misses
    op("R7 below base read", 0, 0, BASE - 16'd4, 0);
    op("R7 misaligned read", 0, 0, BASE + 16'd1, 0);
    op("R7 past end read", 0, 0, reg_of(NF), 0);
    op("R7 miss write", 0, 1, BASE + 16'd2, 0);
    op("R7 still held after miss write", 2, 0, reg_of(4), 0);
    // R4: owner release then fresh read
    op("R4 owner release", 2, 1, reg_of(2), 0);
    op("R4 read after release is free", 2, 0, reg_of(6), 0);
    op("R4 release by new owner", 0, 1, reg_of(6), 0);

    // R9: same-cycle contention, port 0 and port 2 both read
    @(negedge clk);
    cmd_valid = 3'b101;
    cmd_write = 3'b000;
    cmd_addr[0 +: AW]    = reg_of(1);
    cmd_addr[2*AW +: AW] = reg_of(5);
    #1;
    chk("R9 lowest port ready only", {29'd0, cmd_ready}, 32'h1);
    @(negedge clk);
    cmd_valid[0] = 1'b0;
    chk("R10 only port0 responds", {29'd0, rsp_valid}, 32'h1);
    r0 = rsp_rdata[0 +: DW];
    chk("R9 winner acquires", r0, 32'h0);
    #1;
    chk("R9 loser granted next", {29'd0, cmd_ready}, 32'h4);
    @(negedge clk);
    cmd_valid[2] = 1'b0;
    chk("R10 port2 responds", {29'd0, rsp_valid}, 32'h4);
    r2 = rsp_rdata[2*DW +: DW];
    chk("R9 loser sees busy owner 1", r2, 32'h101);
    m_busy = 1;
    m_owner = 1;
    @(negedge clk);
    chk("R10 response is one cycle", {29'd0, rsp_valid}, 32'h0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int p, k, f;
      bit wr;
      logic [AW-1:0] a;
      logic [31:0] d;
      p  = int'($urandom % NP);
      wr = ($urandom % 2) == 1;
      k  = int'($urandom % 10);
      f  = int'($urandom % NF);
      if (wr && k < 5 && m_busy) f = m_owner;
      if (k == 8) a = BASE + AW'(($urandom % (NF * STR)) | 1);
      else if (k == 9) a = reg_of(NF) + AW'($urandom % 64);
      else a = reg_of(f);
      d = ($urandom % 3 == 0) ? $urandom : 32'h0;
      op("R2 random read", p, wr, a, d);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule